// File: doc/BRIEF.md
# Ones' Complement Arithmetic Unit

This block adds, subtracts and negates words held in ones' complement form, and answers two comparison questions about its operands. A negative number is the bitwise inverse of its positive magnitude. So there are two encodings of zero: all bits clear and all bits set. Addition folds the carry out of the top bit back into the bottom bit, which is the end-around carry. Subtraction adds the inverse of the second operand.

A final stage looks at every arithmetic result. When the result is all ones, it rewrites it as all zeros, so that a zero result always leaves the unit in the all-clear form. The zero test and the equality test treat the two zero encodings as the same value.

Each operation is presented with a valid strobe. The result and flags are registered and appear one clock later with an output-valid strobe. The word width is a parameter and defaults to 8 bits.

Top module: `oc_alu`

## Requirements
- R1: With op = 3'b000 (add), result is a plus b with the carry out of bit W-1 added back into bit 0, after the zero rewrite of R4.
- R2: With op = 3'b001 (subtract), result is a plus the bitwise inverse of b, with end-around carry, after the zero rewrite of R4. For example, 8'h03 minus 8'h03 yields 8'h00.
- R3: With op = 3'b010 (negate), result is the bitwise inverse of a, after the zero rewrite of R4. For example, 8'h02 gives 8'hFD, and both 8'h00 and 8'hFF give 8'h00.
- R4: The result is never all ones while out_valid is high. An all-ones value from add, subtract or negate is delivered as all zeros.
- R5: ovf is high only for add or subtract. It is high when both addends (b already inverted for subtract) share a sign bit and the result before the zero rewrite has the other sign bit. It is low for every other op.
- R6: zero is high for add, subtract and negate when the delivered result is zero. With op = 3'b100 (zero test), zero is high when a is all zeros or all ones, and result is 0. For every other op, zero is low.
- R7: With op = 3'b011 (equality test), equal is high when a and b match bit for bit, or when one is all zeros and the other all ones, and result is 0. equal is low for every other op.
- R8: out_valid is high exactly in the cycle after a cycle with in_valid high. While in_valid is low, result and all flags hold their values.
- R9: After reset, out_valid, result, ovf, zero and equal are all 0.
- R10: Op codes 3'b101 to 3'b111 are reserved. They deliver result 0 with ovf, zero and equal low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 3 | Operation select (see R1 to R10) |
| a | input | W | First operand |
| b | input | W | Second operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | W | Normalized result word |
| ovf | output | 1 | Signed overflow flag |
| zero | output | 1 | Zero flag |
| equal | output | 1 | Equality flag |

## Verification
The assertions assume that op, a and b are stable and known whenever in_valid is sampled high. They also assume reset is held long enough for the registers to clear. The stimulus changes inputs only on the falling edge and drives every op code, including the reserved ones. Exhaustive add and subtract sweeps at the default width reach both zero encodings and both overflow directions. Random mixed operations and idle gaps exercise the hold behaviour.

// File: rtl/oc_alu.sv
module oc_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic         ovf,
  output logic         zero,
  output logic         equal
);
  localparam logic [2:0] OP_ADD = 3'b000;
  localparam logic [2:0] OP_SUB = 3'b001;
  localparam logic [2:0] OP_NEG = 3'b010;
  localparam logic [2:0] OP_EQ  = 3'b011;
  localparam logic [2:0] OP_ZT  = 3'b100;
  localparam logic [W-1:0] ONES = '1;

  logic         arith;
  logic [W-1:0] addend;
  logic [W:0]   first;
  logic [W-1:0] raw;
  logic [W-1:0] pick;
  logic [W-1:0] norm;
  logic         a_zero;
  logic         b_zero;
  logic         ovf_n;
  logic         zero_n;
  logic         eq_n;

  assign arith  = (op == OP_ADD) || (op == OP_SUB);
  assign addend = (op == OP_SUB) ? ~b : b;
  assign first  = {1'b0, a} + {1'b0, addend};
  assign raw    = first[W-1:0] + {{(W-1){1'b0}}, first[W]};

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: pick = raw;
      OP_NEG:         pick = ~a;
      default:        pick = '0;
    endcase
  end

  assign norm   = (pick == ONES) ? '0 : pick;
  assign a_zero = (a == '0) || (a == ONES);
  assign b_zero = (b == '0) || (b == ONES);
  assign ovf_n  = arith && (a[W-1] == addend[W-1]) && (raw[W-1] != a[W-1]);
  assign eq_n   = (op == OP_EQ) && ((a == b) || (a_zero && b_zero));

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_NEG: zero_n = (norm == '0);
      OP_ZT:                  zero_n = a_zero;
      default:                zero_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      zero      <= 1'b0;
      equal     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= norm;
        ovf    <= ovf_n;
        zero   <= zero_n;
        equal  <= eq_n;
      end
    end
  end

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(result) && $stable(ovf) && $stable(zero) && $stable(equal));
  // R4
  no_neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> result != ONES);
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !arith |=> !ovf);
  // R7
  eq_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op != OP_EQ |=> !equal);
  // R3
  neg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_NEG && (a == '0 || a == ONES) |=> result == '0 && zero);
  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == OP_ADD || op == OP_SUB || op == OP_NEG) |=> zero == (result == '0));
endmodule

// File: tb/sim_oc_alu.sv
module sim_oc_alu;
  localparam int W = 8;
  localparam int M = (1 << W) - 1;
  localparam int MAXV = (1 << (W - 1)) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [2:0]   op = '0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         out_valid;
  logic [W-1:0] result;
  logic         ovf;
  logic         zero;
  logic         equal;

  int n_chk = 0;
  int n_bad = 0;
  bit pend = 0;
  bit done = 0;
  logic [W-1:0] e_res;
  logic e_ovf, e_zero, e_eq;
  string e_tag;

  always #10 clk = ~clk;

  oc_alu #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .a(a), .b(b),
    .out_valid(out_valid), .result(result), .ovf(ovf), .zero(zero), .equal(equal)
  );

  function automatic int val(logic [W-1:0] x);
    logic [W-1:0] m;
    m = ~x;
    return x[W-1] ? -int'(m) : int'(x);
  endfunction

  function automatic logic [W-1:0] enc(int s);
    logic [W-1:0] t;
    if (s < 0) begin
      t = W'(-s);
      return ~t;
    end
    return W'(s);
  endfunction

  task automatic model(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    int s;
    e_res = '0; e_ovf = 0; e_zero = 0; e_eq = 0;
    case (o)
      3'b000, 3'b001: begin
        s = (o == 3'b000) ? val(x) + val(y) : val(x) - val(y);
        e_ovf = (s > MAXV) || (s < -MAXV);
        if (s > MAXV) s -= M;
        if (s < -MAXV) s += M;
        e_res = enc(s);
        e_zero = (s == 0);
      end
      3'b010: begin
        e_res = enc(-val(x));
        e_zero = (val(x) == 0);
      end
      3'b011: e_eq = (val(x) == val(y));
      3'b100: e_zero = (val(x) == 0);
      default: ;
    endcase
  endtask

  task automatic check_pending();
    if (pend) begin
      n_chk++;
      if (!out_valid || result !== e_res || ovf !== e_ovf || zero !== e_zero || equal !== e_eq) begin
        n_bad++;
        $display("FAIL %s: got v=%b res=%h ovf=%b z=%b eq=%b, expected v=1 res=%h ovf=%b z=%b eq=%b",
                 e_tag, out_valid, result, ovf, zero, equal, e_res, e_ovf, e_zero, e_eq);
      end
    end
  endtask

  task automatic apply(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y, input string tag);
    @(negedge clk);
    check_pending();
    in_valid = 1'b1; op = o; a = x; b = y;
    model(o, x, y);
    e_tag = tag;
    pend = 1;
  endtask

  task automatic idle_hold();
    logic [W-1:0] keep;
    logic [2:0] kf;
    @(negedge clk);
    check_pending();
    pend = 0;
    in_valid = 1'b0;
    op = 3'($urandom_range(0, 7)); a = W'($urandom); b = W'($urandom);
    keep = result;
    kf = {ovf, zero, equal};
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || result !== keep || {ovf, zero, equal} !== kf) begin
      n_bad++;
      $display("FAIL R8: got v=%b res=%h flags=%b, expected v=0 res=%h flags=%b",
               out_valid, result, {ovf, zero, equal}, keep, kf);
    end
  endtask

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R7";
      3'b100: return "R6";
      default: return "R10";
    endcase
  endfunction

  initial begin
    process::self().srandom(32'h5eed_0c01);
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 0 || result !== '0 || ovf !== 0 || zero !== 0 || equal !== 0) begin
      n_bad++;
      $display("FAIL R9: got v=%b res=%h ovf=%b z=%b eq=%b, expected all 0",
               out_valid, result, ovf, zero, equal);
    end
    rst_n = 1'b1;

    apply(3'b001, 8'h03, 8'h03, "R4");
    apply(3'b010, 8'h02, 8'h00, "R3");
    apply(3'b010, 8'hFF, 8'h00, "R4");
    apply(3'b010, 8'h00, 8'h00, "R3");
    apply(3'b000, 8'h7F, 8'h01, "R5");
    apply(3'b000, 8'h80, 8'hFE, "R5");
    apply(3'b000, 8'hFF, 8'hFF, "R4");
    apply(3'b000, 8'h00, 8'hFF, "R4");
    apply(3'b011, 8'h00, 8'hFF, "R7");
    apply(3'b011, 8'hFF, 8'h00, "R7");
    apply(3'b011, 8'h12, 8'h13, "R7");
    apply(3'b100, 8'hFF, 8'h00, "R6");
    apply(3'b100, 8'h01, 8'h00, "R6");
    apply(3'b101, 8'hFF, 8'hFF, "R10");
    apply(3'b111, 8'h7F, 8'h01, "R10");
    idle_hold();

    for (int i = 0; i < (1 << W); i++)
      for (int j = 0; j < (1 << W); j++)
        apply(3'b000, W'(i), W'(j), "R1");
    for (int i = 0; i < (1 << W); i++)
      for (int j = 0; j < (1 << W); j++)
        apply(3'b001, W'(i), W'(j), "R2");
    for (int i = 0; i < (1 << W); i++)
      apply(3'b010, W'(i), '0, "R3");
    for (int i = 0; i < (1 << W); i++)
      apply(3'b100, W'(i), '0, "R6");

    for (int k = 0; k < 4000; k++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      if (k % 97 == 0) idle_hold();
      apply(o, W'($urandom), W'($urandom), tag_of(o));
    end
    idle_hold();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got no completion, expected finish before timeout");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule